// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It steps an external analog front end through a repeating four-phase cycle by presenting a two-bit phase code to the front end's switch decoder. It times a fixed input window with a counter. It then reuses that counter to measure how long the integrator takes to run back to zero against the reference. The end of that run is signalled by a falling edge on the front end's comparator output.

Each finished measurement produces a magnitude word, a sign taken from the front end's polarity detector and an over-range flag, together with a one-clock valid strobe. The block then discharges the integrator, auto-zeroes and starts again for as long as it is enabled. The comparator is asynchronous to the clock, so it passes through a two-stage synchronizer before its falling edge is detected. The magnitude therefore includes two clocks of synchronizer latency, which a host removes or calibrates out. Phase lengths and the magnitude width are parameters.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is held and on the first clock after it, the phase code is 00 (auto zero) and the magnitude, sign, over-range and valid outputs are all 0.
- R2: The phase code always advances in the repeating order 00 (auto zero), 01 (input integrate), 10 (reference deintegrate), 11 (integrator zero), and never skips or reverses.
- R3: With enable high, auto zero lasts AZ_CYC clocks, integrate lasts INT_CYC clocks and integrator zero lasts IZ_CYC clocks; each parameter is at least 1.
- R4: The phase code changes from 01 straight to 10 on the clock that ends the integrate window, with no idle clock between them.
- R5: If the comparator input falls during deintegrate cycle D (cycle 0 being the first clock with phase 10), the magnitude equals D+2, and deintegrate lasts D+3 clocks.
- R6: If no synchronized comparator fall occurs within 2^MAG_W deintegrate clocks, deintegrate ends after exactly 2^MAG_W clocks, the magnitude is all ones and over-range is 1. A fall seen on the last of those clocks gives an all-ones magnitude with over-range 0.
- R7: The sign output equals the polarity input sampled on the last integrate clock (1 = negative input). The ref_neg output is high during deintegrate only when that sampled polarity is 0, and it is low in every other phase.
- R8: res_valid is high for exactly one clock, which is the first clock of phase 11. Magnitude, sign and over-range change only with it and hold until the next strobe.
- R9: With enable low, the block stays in auto zero once it gets there. A conversion already past auto zero still runs to completion and delivers its result.
- R10: Comparator falls outside deintegrate, and rising edges in any phase, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows a new conversion to leave auto zero |
| cmp_in | input | 1 | Asynchronous comparator output from the front end |
| pol_in | input | 1 | Polarity detector output (1 = negative input) |
| phase_code | output | 2 | Current phase: 00 auto zero, 01 integrate, 10 deintegrate, 11 integrator zero |
| ref_neg | output | 1 | Selects the negative reference during deintegrate |
| mag | output | MAG_W | Latched conversion magnitude |
| sign | output | 1 | Latched sign of the conversion |
| ovr | output | 1 | Latched over-range flag |
| res_valid | output | 1 | One-clock strobe marking a new result |

## Verification
A wrong phase or counter value shows up directly on phase_code. The bench times every phase against its parameter, so a length error appears within one conversion. It also catches a delayed start of deintegrate on the clock the integrate window ends. A counter or synchronizer fault shifts the magnitude away from D+2 or changes the deintegrate length, which is visible at the next valid strobe. A mis-captured polarity shows on ref_neg during that same deintegrate phase and on sign at the strobe.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    typedef enum logic [1:0] {
        PH_AZ    = 2'b00,
        PH_INT   = 2'b01,
        PH_DEINT = 2'b10,
        PH_IZ    = 2'b11
    } phase_e;
endpackage

// File: rtl/dsq_sync.sv
// Multi-stage synchronizer with falling-edge detector on its output.
module dsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out,
    output logic fall_pulse
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < CHAIN; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out   = chain_q[STAGES-1];
    assign fall_pulse = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/dsq_result.sv
// Result holding register with one-clock valid strobe.
module dsq_result #(
    parameter int MAG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [MAG_W-1:0] mag_in,
    input  logic             sign_in,
    input  logic             ovr_in,
    output logic [MAG_W-1:0] mag,
    output logic             sign,
    output logic             ovr,
    output logic             valid
);
    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             sign;
        logic             ovr;
        logic             valid;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d       = res_q;
        res_d.valid = capture;
        if (capture) begin
            res_d.mag  = mag_in;
            res_d.sign = sign_in;
            res_d.ovr  = ovr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign mag   = res_q.mag;
    assign sign  = res_q.sign;
    assign ovr   = res_q.ovr;
    assign valid = res_q.valid;

    // R6: an over-range result always carries a saturated magnitude
    p_ovr_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.ovr |-> (&res_q.mag));

    // R8: the strobe never lasts two clocks
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_q.valid |=> !res_q.valid);
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
    parameter int MAG_W   = 18,
    parameter int INT_CYC = 1000,
    parameter int AZ_CYC  = 16,
    parameter int IZ_CYC  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cmp_in,
    input  logic             pol_in,
    output logic [1:0]       phase_code,
    output logic             ref_neg,
    output logic [MAG_W-1:0] mag,
    output logic             sign,
    output logic             ovr,
    output logic             res_valid
);
    import dsq_pkg::*;

    localparam int               CNT_W    = MAG_W;
    localparam logic [CNT_W-1:0] AZ_LAST  = CNT_W'(AZ_CYC - 1);
    localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_CYC - 1);
    localparam logic [CNT_W-1:0] IZ_LAST  = CNT_W'(IZ_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             pol;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             cmp_sync;
    logic             cmp_fall;
    logic             cap_d;
    logic             ovr_d;
    logic [MAG_W-1:0] mag_d;

    dsq_sync #(.STAGES(2)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (cmp_in),
        .sync_out   (cmp_sync),
        .fall_pulse (cmp_fall)
    );

    always_comb begin
        seq_d = seq_q;
        cap_d = 1'b0;
        ovr_d = 1'b0;
        mag_d = seq_q.cnt;
        unique case (seq_q.phase)
            PH_AZ: begin
                if (!en) begin
                    seq_d.cnt = '0;
                end else if (seq_q.cnt == AZ_LAST) begin
                    seq_d.phase = PH_INT;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                end
            end
            PH_INT: begin
                if (seq_q.cnt == INT_LAST) begin
                    seq_d.phase = PH_DEINT;
                    seq_d.cnt   = '0;
                    seq_d.pol   = pol_in;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                end
            end
            PH_DEINT: begin
                if (cmp_fall) begin
                    cap_d       = 1'b1;
                    seq_d.phase = PH_IZ;
                    seq_d.cnt   = '0;
                end else if (&seq_q.cnt) begin
                    cap_d       = 1'b1;
                    ovr_d       = 1'b1;
                    mag_d       = '1;
                    seq_d.phase = PH_IZ;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                end
            end
            PH_IZ: begin
                if (seq_q.cnt == IZ_LAST) begin
                    seq_d.phase = PH_AZ;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_ONE;
                end
            end
            default: seq_d = seq_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= PH_AZ;
            seq_q.cnt   <= '0;
            seq_q.pol   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    dsq_result #(.MAG_W(MAG_W)) result_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_d),
        .mag_in  (mag_d),
        .sign_in (seq_q.pol),
        .ovr_in  (ovr_d),
        .mag     (mag),
        .sign    (sign),
        .ovr     (ovr),
        .valid   (res_valid)
    );

    assign phase_code = seq_q.phase;
    assign ref_neg    = (seq_q.phase == PH_DEINT) && !seq_q.pol;

    // R2: the phase only ever steps forward by one code
    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code != $past(phase_code)) |-> (phase_code == 2'($past(phase_code) + 2'd1)));

    // R4: deintegrate starts on the clock that closes the integrate window
    p_int_to_deint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_INT && seq_q.cnt == INT_LAST) |=> (phase_code == 2'b10 && seq_q.cnt == '0));

    // R9: without enable the block rests in auto zero
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && seq_q.phase == PH_AZ) |=> (phase_code == 2'b00));

    // R8: the result only moves at the end of deintegrate
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_DEINT) |=> ($stable(mag) && $stable(sign) && $stable(ovr)));
endmodule

// File: tb/dsadc_seq_tb_top.sv
module dsadc_seq_tb_top;
    localparam int MAG_W   = 6;
    localparam int INT_CYC = 12;
    localparam int AZ_CYC  = 3;
    localparam int IZ_CYC  = 2;
    localparam int FULL    = 1 << MAG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b1;
    logic             cmp_in = 1'b1;
    logic             pol_in = 1'b0;
    logic [1:0]       phase_code;
    logic             ref_neg;
    logic [MAG_W-1:0] mag;
    logic             sign;
    logic             ovr;
    logic             res_valid;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit have_last = 1'b0;
    logic [MAG_W+1:0] last_res = '0;
    logic [MAG_W+1:0] exp_q[$];

    always #4 clk = ~clk;

    dsadc_seq #(
        .MAG_W(MAG_W), .INT_CYC(INT_CYC), .AZ_CYC(AZ_CYC), .IZ_CYC(IZ_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cmp_in(cmp_in), .pol_in(pol_in),
        .phase_code(phase_code), .ref_neg(ref_neg), .mag(mag), .sign(sign),
        .ovr(ovr), .res_valid(res_valid)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: scoreboard pop on each strobe, hold check otherwise
    always @(negedge clk) begin
        if (running && rst_n) begin
            if (res_valid) begin
                chk("R8 strobe in first integrator-zero clock", phase_code, 3);
                if (exp_q.size() == 0) begin
                    chk("R8 unexpected strobe", 1, 0);
                end else begin
                    logic [MAG_W+1:0] e;
                    e = exp_q.pop_front();
                    chk("R5/R6 magnitude", mag, e[MAG_W-1:0]);
                    chk("R7 sign", sign, e[MAG_W]);
                    chk("R6 over-range", ovr, e[MAG_W+1]);
                end
                last_res  = {ovr, sign, mag};
                have_last = 1'b1;
            end else if (have_last) begin
                chk("R8 result hold", {ovr, sign, mag}, last_res);
            end
        end
    end

    task automatic conv(input int d, input logic pol, input logic ovr_case,
                        input logic glitch, input logic drop_en);
        int n;
        int k;
        int m;
        int a;
        while (phase_code != 2'b01) @(negedge clk);
        pol_in = pol;
        n = 0;
        while (phase_code == 2'b01) begin
            // R10: a comparator fall and rise inside integrate must not matter
            if (glitch && n == 1) cmp_in = 1'b0;
            if (glitch && n == 3) cmp_in = 1'b1;
            n++;
            @(negedge clk);
        end
        chk("R3 integrate length", n, INT_CYC);
        chk("R4 deintegrate follows integrate at once", phase_code, 2);
        chk("R7 ref_neg in deintegrate", ref_neg, !pol);
        exp_q.push_back({ovr_case, pol, ovr_case ? MAG_W'(FULL - 1) : MAG_W'(d + 2)});
        if (drop_en) en = 1'b0;
        k = 0;
        while (phase_code == 2'b10) begin
            if (!ovr_case && k == d) cmp_in = 1'b0;
            k++;
            @(negedge clk);
        end
        chk(ovr_case ? "R6 deintegrate length" : "R5 deintegrate length",
            k, ovr_case ? FULL : d + 3);
        cmp_in = 1'b1;
        chk("R7 ref_neg low outside deintegrate", ref_neg, 0);
        m = 0;
        while (phase_code == 2'b11) begin
            m++;
            @(negedge clk);
        end
        chk("R3 integrator zero length", m, IZ_CYC);
        if (!drop_en) begin
            a = 0;
            while (phase_code == 2'b00) begin
                a++;
                @(negedge clk);
            end
            chk("R3 auto zero length", a, AZ_CYC);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset phase", phase_code, 0);
        chk("R1 reset outputs", {mag, sign, ovr, res_valid}, 0);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        chk("R1 first clock phase", phase_code, 0);
        chk("R1 first clock valid", res_valid, 0);
        conv(0, 1'b0, 1'b0, 1'b0, 1'b0);
        conv(10, 1'b1, 1'b0, 1'b1, 1'b0);   // R10 glitch case
        conv(FULL - 3, 1'b0, 1'b0, 1'b0, 1'b0); // R6 fall on last count
        conv(0, 1'b1, 1'b1, 1'b0, 1'b0);    // R6 over-range
        conv(30, 1'b0, 1'b0, 1'b0, 1'b1);   // R9 enable dropped mid-conversion
        for (int i = 0; i < 20; i++) begin
            chk("R9 rest in auto zero", phase_code, 0);
            @(negedge clk);
        end
        en = 1'b1;
        conv(5, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R8 all results delivered", exp_q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule